// File: doc/BRIEF.md
# Time-over-threshold hit buffer

This block records hits for a small group of pixels in one column of a pixel readout chip. It runs on the 40 MHz sampling clock, so each time bin is 25 ns. Every pixel drives one discriminator output. For each pixel, the block notes the clock bin in which the output first went high and the bin in which it fell. The number of bins the output stayed high is the hit amplitude, called the time over threshold (ToT). A pixel that never crosses threshold produces nothing, so zero suppression happens inside each pixel.

Finished hits go into a small shared buffer. Each entry holds the pixel address, the leading-edge time stamp and the ToT. An entry waits there for a trigger that arrives exactly a programmed latency after its leading edge. A matching trigger marks the entry for read-out. An entry that reaches its latency without a trigger is dropped. Marked entries leave on a single serial line as framed address-plus-ToT words. Hits that find the buffer full are counted.

Top module: `tot_hit_buffer`

## Requirements
- R1: While reset is held and after it is released with no discriminator activity, `sout_o` stays low and `ovf_cnt_o` reads zero.
- R2: A hit's leading edge is the first clock edge at which the pixel's comparator is sampled high. Its ToT is the number of consecutive edges at which the comparator is sampled high, taken modulo 256.
- R3: Triggers alone never produce output. A pixel creates a record only after at least one high sample followed by a low sample.
- R4: A trigger sampled at edge r+LAT selects every buffered, unselected hit whose leading edge was edge r, for LAT from 1 to 255 and with edge distance taken modulo 256. At the first edge where an unselected hit's distance is at least LAT and it is not selected, the hit is discarded and never sent.
- R5: The buffer has 16 slots and accepts at most one hit per clock. When several pixels hold finished hits, the lowest pixel index is written first and the others wait in their pixels. Each hit goes into the lowest-numbered free slot. A slot freed at an edge can be reused from the next edge on.
- R6: A finished hit that finds no free slot is discarded, and `ovf_cnt_o` rises by exactly one. The counter saturates at its maximum value.
- R7: Each frame is 22 bits sent MSB first, one bit per clock: a start bit of 1, then a 5-bit column (equal to COL_ID), then an 8-bit row (ROW_BASE plus the pixel index), then the 8-bit ToT. The line is low when no frame is being sent.
- R8: Selected hits are sent lowest slot first. The start bit appears one clock after selection if the line is free. A waiting frame's start bit follows the previous frame's last bit with no idle clock between them.
- R9: A rising comparator edge that arrives while its pixel still holds an unwritten hit is ignored, and the whole pulse it starts is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| comp_i | input | NPIX | Discriminator output for each pixel |
| trig_i | input | 1 | Trigger, sampled on each clock edge |
| lat_i | input | 8 | Trigger latency in clocks (1 to 255) |
| sout_o | output | 1 | Serial hit output |
| ovf_cnt_o | output | OVF_W | Number of hits lost because the buffer was full |

## Verification
The bench targets latency edges one clock on either side of the exact match. A design with an off-by-one age comparison would send a hit it should drop, or lose one it should keep. Four pixels finish together while a pixel that is still waiting pulses again. An arbiter that grants out of order, or a pixel that accepts a new edge while it holds a hit, changes the frame order or the frame count. A pulse 258 clocks long checks that ToT and age both wrap modulo 256. A train of twenty hits held at a long latency checks that exactly four are counted as overflow, and a later hit checks that the freed slots work again.

// File: rtl/tot_hit_pkg.sv
package tot_hit_pkg;
  localparam int TS_W    = 8;
  localparam int COL_W   = 5;
  localparam int ROW_W   = 8;
  localparam int ADDR_W  = COL_W + ROW_W;
  localparam int WORD_W  = ADDR_W + TS_W;
  localparam int FRAME_W = 1 + WORD_W;

  typedef enum logic [1:0] {
    PX_IDLE = 2'd0,
    PX_HIGH = 2'd1,
    PX_PEND = 2'd2
  } px_state_e;
endpackage

// File: rtl/tot_pixel_edge.sv
module tot_pixel_edge
  import tot_hit_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            comp_i,
  input  logic [TS_W-1:0] ts_i,
  input  logic            grant_i,
  output logic            pend_o,
  output logic [TS_W-1:0] lead_o,
  output logic [TS_W-1:0] tot_o
);
  px_state_e       state_q, state_d;
  logic            comp_q;
  logic [TS_W-1:0] lead_q, lead_d, tot_q, tot_d;
  logic            rise, fall;

  assign rise = comp_i & ~comp_q;
  assign fall = ~comp_i & comp_q;

  always_comb begin
    state_d = state_q;
    lead_d  = lead_q;
    tot_d   = tot_q;
    case (state_q)
      PX_IDLE: if (rise) begin
        state_d = PX_HIGH;
        lead_d  = ts_i;
      end
      PX_HIGH: if (fall) begin
        state_d = PX_PEND;
        tot_d   = ts_i - lead_q;
      end
      PX_PEND: if (grant_i) state_d = PX_IDLE;
      default: state_d = PX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PX_IDLE;
      comp_q  <= 1'b0;
      lead_q  <= '0;
      tot_q   <= '0;
    end else begin
      state_q <= state_d;
      comp_q  <= comp_i;
      lead_q  <= lead_d;
      tot_q   <= tot_d;
    end
  end

  assign pend_o = (state_q == PX_PEND);
  assign lead_o = lead_q;
  assign tot_o  = tot_q;

  // R5: a finished hit waits in the pixel until it is granted
  p_pend_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PX_PEND && !grant_i) |=> (state_q == PX_PEND));

  // R9: while a hit is waiting, a new edge cannot overwrite its time stamp
  p_ignore_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PX_PEND) |=> $stable(lead_q));
endmodule

// File: rtl/tot_hit_store.sv
module tot_hit_store
  import tot_hit_pkg::*;
#(
  parameter int NPIX  = 4,
  parameter int DEPTH = 16,
  parameter int OVF_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [TS_W-1:0]                ts_i,
  input  logic [TS_W-1:0]                lat_i,
  input  logic                           trig_i,
  input  logic [NPIX-1:0]                pend_i,
  input  logic [NPIX-1:0][ADDR_W-1:0]    pix_addr_i,
  input  logic [NPIX-1:0][TS_W-1:0]      pix_lead_i,
  input  logic [NPIX-1:0][TS_W-1:0]      pix_tot_i,
  input  logic                           take_i,
  output logic [NPIX-1:0]                grant_o,
  output logic [OVF_W-1:0]               ovf_cnt_o,
  output logic                           word_vld_o,
  output logic [WORD_W-1:0]              word_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PIX_W = (NPIX > 1) ? $clog2(NPIX) : 1;

  logic [DEPTH-1:0] vld_q, vld_d, sel_q, sel_d;
  logic [ADDR_W-1:0] s_addr [DEPTH];
  logic [TS_W-1:0]   s_lead [DEPTH];
  logic [TS_W-1:0]   s_tot  [DEPTH];
  logic [TS_W-1:0]   age    [DEPTH];
  logic [OVF_W-1:0]  ovf_q, ovf_d;

  logic             any_pend, have_free, wr_en;
  logic [PIX_W-1:0] gidx;
  logic [IDX_W-1:0] fidx, oidx;

  // lowest-index pending pixel wins the write port
  always_comb begin
    any_pend = 1'b0;
    gidx     = '0;
    grant_o  = '0;
    for (int p = 0; p < NPIX; p++) begin
      if (pend_i[p] && !any_pend) begin
        any_pend = 1'b1;
        gidx     = PIX_W'(p);
      end
    end
    if (any_pend) grant_o[gidx] = 1'b1;
  end

  // lowest free slot and lowest selected slot
  always_comb begin
    have_free  = 1'b0;
    fidx       = '0;
    word_vld_o = 1'b0;
    oidx       = '0;
    for (int s = 0; s < DEPTH; s++) begin
      if (!vld_q[s] && !have_free) begin
        have_free = 1'b1;
        fidx      = IDX_W'(s);
      end
      if (vld_q[s] && sel_q[s] && !word_vld_o) begin
        word_vld_o = 1'b1;
        oidx       = IDX_W'(s);
      end
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_age
    assign age[s] = ts_i - s_lead[s];
  end

  assign wr_en = any_pend && have_free;

  always_comb begin
    vld_d = vld_q;
    sel_d = sel_q;
    for (int s = 0; s < DEPTH; s++) begin
      if (vld_q[s] && !sel_q[s]) begin
        if (trig_i && (age[s] == lat_i)) sel_d[s] = 1'b1;
        else if (age[s] >= lat_i)        vld_d[s] = 1'b0;
      end
    end
    if (take_i && word_vld_o) begin
      vld_d[oidx] = 1'b0;
      sel_d[oidx] = 1'b0;
    end
    if (wr_en) begin
      vld_d[fidx] = 1'b1;
      sel_d[fidx] = 1'b0;
    end
    ovf_d = ovf_q;
    if (any_pend && !have_free && (ovf_q != {OVF_W{1'b1}})) ovf_d = ovf_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      sel_q <= '0;
      ovf_q <= '0;
    end else begin
      vld_q <= vld_d;
      sel_q <= sel_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      s_addr[fidx] <= pix_addr_i[gidx];
      s_lead[fidx] <= pix_lead_i[gidx];
      s_tot[fidx]  <= pix_tot_i[gidx];
    end
  end

  assign ovf_cnt_o = ovf_q;
  assign word_o    = {s_addr[oidx], s_tot[oidx]};

  // R6: the loss counter moves by one step at most
  p_ovf_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q != $past(ovf_q)) |-> (ovf_q == $past(ovf_q) + 1'b1));

  // R6: a loss is only counted when every slot was occupied
  p_ovf_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q != $past(ovf_q)) |-> (&$past(vld_q)));

  for (genvar s = 0; s < DEPTH; s++) begin : g_chk
    // R8: a selected hit stays queued until the serializer takes it
    p_sel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q[s] && sel_q[s] && !(take_i && word_vld_o && oidx == IDX_W'(s)))
      |=> (vld_q[s] && sel_q[s]));
  end
endmodule

// File: rtl/tot_serializer.sv
module tot_serializer
  import tot_hit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              take_o,
  output logic              sout_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  assign take_o = word_vld_i && (cnt_q <= CNT_W'(1));

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (take_o) begin
      sr_d  = {1'b1, word_i};
      cnt_d = CNT_W'(FRAME_W);
    end else if (cnt_q != '0) begin
      sr_d  = {sr_q[FRAME_W-2:0], 1'b0};
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign sout_o = (cnt_q != '0) && sr_q[FRAME_W-1];

  // R7: a frame always opens with a high start bit
  p_start_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> sout_o);
endmodule

// File: rtl/tot_hit_buffer.sv
module tot_hit_buffer
  import tot_hit_pkg::*;
#(
  parameter int NPIX     = 4,
  parameter int DEPTH    = 16,
  parameter int OVF_W    = 8,
  parameter int COL_ID   = 3,
  parameter int ROW_BASE = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPIX-1:0]  comp_i,
  input  logic             trig_i,
  input  logic [TS_W-1:0]  lat_i,
  output logic             sout_o,
  output logic [OVF_W-1:0] ovf_cnt_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [TS_W-1:0]  ts_q;

  logic [NPIX-1:0]             pend, grant;
  logic [NPIX-1:0][ADDR_W-1:0] pix_addr;
  logic [NPIX-1:0][TS_W-1:0]   pix_lead, pix_tot;
  logic                        word_vld, take;
  logic [WORD_W-1:0]           word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ts_q <= '0;
    else            ts_q <= ts_q + 1'b1;
  end

  for (genvar i = 0; i < NPIX; i++) begin : g_pix
    assign pix_addr[i] = {COL_W'(COL_ID), ROW_W'(ROW_BASE + i)};
    tot_pixel_edge u_pix (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .comp_i  (comp_i[i]),
      .ts_i    (ts_q),
      .grant_i (grant[i]),
      .pend_o  (pend[i]),
      .lead_o  (pix_lead[i]),
      .tot_o   (pix_tot[i])
    );
  end

  tot_hit_store #(.NPIX(NPIX), .DEPTH(DEPTH), .OVF_W(OVF_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ts_i       (ts_q),
    .lat_i      (lat_i),
    .trig_i     (trig_i),
    .pend_i     (pend),
    .pix_addr_i (pix_addr),
    .pix_lead_i (pix_lead),
    .pix_tot_i  (pix_tot),
    .take_i     (take),
    .grant_o    (grant),
    .ovf_cnt_o  (ovf_cnt_o),
    .word_vld_o (word_vld),
    .word_o     (word)
  );

  tot_serializer u_ser (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .word_vld_i (word_vld),
    .word_i     (word),
    .take_o     (take),
    .sout_o     (sout_o)
  );
endmodule

// File: tb/tot_hit_buffer_bench.sv
module tot_hit_buffer_bench;
  localparam int NP = 4;
  localparam int ND = 16;
  localparam int COLV = 3;
  localparam int ROWB = 40;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] comp;
  logic       trig;
  logic [7:0] lat;
  logic       sout;
  logic [7:0] ovf;

  always #4 clk = ~clk;

  tot_hit_buffer #(.NPIX(NP), .DEPTH(ND), .OVF_W(8), .COL_ID(COLV), .ROW_BASE(ROWB))
    u_tot_hit_buffer (
      .clk(clk), .rst_n(rst_n), .comp_i(comp), .trig_i(trig), .lat_i(lat),
      .sout_o(sout), .ovf_cnt_o(ovf));

  int    n_vec = 0, n_bad = 0, cyc = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_st [NP];
  int m_cq [NP];
  int m_pld[NP];
  int m_ptot[NP];
  bit m_v  [ND];
  bit m_sl [ND];
  int m_ad [ND];
  int m_ld [ND];
  int m_tt [ND];
  int m_ts, m_ovf;
  bit bq[$];

  // decoded frames from the design's line
  int frames[$];
  int starts[$];
  bit in_fr = 0;
  int fr_bits, fr_val;

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp, string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic int fword(int p, int tot);
    return (COLV << 16) | ((ROWB + p) << 8) | (tot & 255);
  endfunction

  always @(posedge clk) begin
    int g, f, t, age;
    cyc++;
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin m_st[p] = 0; m_cq[p] = 0; m_pld[p] = 0; m_ptot[p] = 0; end
      for (int s = 0; s < ND; s++) begin m_v[s] = 0; m_sl[s] = 0; end
      m_ts = 0; m_ovf = 0; bq.delete();
    end else begin
      g = -1; f = -1; t = -1;
      for (int p = 0; p < NP; p++) if (g < 0 && m_st[p] == 2) g = p;
      for (int s = 0; s < ND; s++) if (f < 0 && !m_v[s]) f = s;
      if (bq.size() <= 1)
        for (int s = 0; s < ND; s++) if (t < 0 && m_v[s] && m_sl[s]) t = s;
      for (int s = 0; s < ND; s++) begin
        if (m_v[s] && !m_sl[s]) begin
          age = (m_ts - m_ld[s]) & 255;
          if (trig && age == lat) m_sl[s] = 1;
          else if (age >= lat) m_v[s] = 0;
        end
      end
      if (bq.size() > 0) void'(bq.pop_front());
      if (t >= 0) begin
        int w;
        w = (m_ad[t] << 8) | m_tt[t];
        m_v[t] = 0; m_sl[t] = 0;
        bq.push_back(1'b1);
        for (int b = 20; b >= 0; b--) bq.push_back(w[b]);
      end
      if (g >= 0) begin
        if (f >= 0) begin
          m_v[f] = 1; m_sl[f] = 0;
          m_ad[f] = (COLV << 8) | (ROWB + g);
          m_ld[f] = m_pld[g]; m_tt[f] = m_ptot[g];
        end else if (m_ovf < 255) m_ovf++;
      end
      for (int p = 0; p < NP; p++) begin
        bit rise, fall;
        rise = comp[p] && !m_cq[p];
        fall = !comp[p] && m_cq[p];
        case (m_st[p])
          0: if (rise) begin m_st[p] = 1; m_pld[p] = m_ts; end
          1: if (fall) begin m_st[p] = 2; m_ptot[p] = (m_ts - m_pld[p]) & 255; end
          default: if (g == p) m_st[p] = 0;
        endcase
        m_cq[p] = comp[p];
      end
      m_ts = (m_ts + 1) & 255;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, sout, (bq.size() > 0) ? bq[0] : 0, "sout vs model");
      check(cur_req, ovf, m_ovf, "ovf count vs model");
      if (!in_fr && sout) begin
        in_fr = 1; fr_bits = 0; fr_val = 0; starts.push_back(cyc);
      end else if (in_fr) begin
        fr_val = (fr_val << 1) | sout;
        fr_bits++;
        if (fr_bits == 21) begin frames.push_back(fr_val); in_fr = 0; end
      end
    end
  end

  task automatic clear_log();
    frames.delete(); starts.delete();
  endtask

  initial begin
    rst_n = 1'b0; comp = '0; trig = 1'b0; lat = 8'd10;
    tick(3);
    check("R1", sout, 0, "sout in reset");
    check("R1", ovf, 0, "ovf in reset");
    rst_n = 1'b1;
    tick(6);
    check("R1", sout, 0, "sout after reset");
    check("R1", ovf, 0, "ovf after reset");

    // R2/R7: single pixel, 3 samples high, trigger exactly LAT later
    cur_req = "R2"; clear_log();
    comp[1] = 1; tick(3); comp[1] = 0; tick(7);
    trig = 1; tick(1); trig = 0; tick(40);
    check("R7", frames.size(), 1, "frame count single hit");
    if (frames.size() > 0) check("R7", frames[0], fword(1, 3), "frame word single hit");

    // R4: triggers one clock early and one clock late
    cur_req = "R4"; clear_log();
    comp[1] = 1; tick(3); comp[1] = 0; tick(6);
    trig = 1; tick(1); trig = 0; tick(1);
    trig = 1; tick(1); trig = 0; tick(40);
    check("R4", frames.size(), 0, "frames with off-by-one triggers");

    // R3: triggers with no discriminator activity
    cur_req = "R3"; clear_log();
    trig = 1; tick(30); trig = 0; tick(30);
    check("R3", frames.size(), 0, "frames from triggers alone");

    // R8: two pixels together, order and gap-free framing
    cur_req = "R8"; clear_log();
    comp = 4'b0101; tick(2); comp = '0; tick(8);
    trig = 1; tick(1); trig = 0; tick(70);
    check("R8", frames.size(), 2, "frame count two pixels");
    if (frames.size() == 2) begin
      check("R8", frames[0], fword(0, 2), "first frame pixel 0");
      check("R8", frames[1], fword(2, 2), "second frame pixel 2");
      check("R8", starts[1] - starts[0], 22, "frame spacing");
    end

    // R9/R5: four pixels finish together, waiting pixel 3 pulses again
    cur_req = "R9"; clear_log(); lat = 8'd20;
    comp = 4'b1111; tick(1); comp = '0; tick(2);
    comp[3] = 1; tick(1); comp[3] = 0; tick(16);
    trig = 1; tick(1); trig = 0; tick(2);
    trig = 1; tick(1); trig = 0; tick(130);
    check("R9", frames.size(), 4, "frames with ignored re-pulse");
    for (int i = 0; i < 4; i++)
      if (frames.size() == 4) check("R5", frames[i], fword(i, 1), "arbitration order");

    // R6: twenty hits held at a long latency, four must overflow
    cur_req = "R6"; clear_log(); lat = 8'd250;
    repeat (20) begin comp[0] = 1; tick(1); comp[0] = 0; tick(2); end
    tick(5);
    check("R6", ovf, 4, "overflow after 20 hits");
    tick(260);
    check("R6", frames.size(), 0, "no frames from untriggered hits");

    // R5: slots freed by discarding can be used again
    cur_req = "R5"; clear_log(); lat = 8'd10;
    comp[1] = 1; tick(3); comp[1] = 0; tick(7);
    trig = 1; tick(1); trig = 0; tick(40);
    check("R5", frames.size(), 1, "frame after slot reuse");
    if (frames.size() > 0) check("R5", frames[0], fword(1, 3), "frame word after reuse");

    // R2/R4: 258-clock pulse, ToT and age both wrap modulo 256
    cur_req = "R4"; clear_log(); lat = 8'd5;
    comp[2] = 1; tick(258); comp[2] = 0; tick(3);
    trig = 1; tick(1); trig = 0; tick(40);
    check("R2", frames.size(), 1, "frame count long pulse");
    if (frames.size() > 0) check("R2", frames[0], fword(2, 2), "wrapped ToT");
    check("R6", ovf, 4, "overflow unchanged");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL R8 watchdog: act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule